// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches 24 external interrupt pins that are asynchronous to its clock. Each pin first passes through a two-flop synchronizer. It is then compared against its own 4-bit trigger setting, which selects active-low level, active-high level, rising edge, falling edge or both edges. Every detected event sets a sticky pending bit. A mask register decides which pending bits may reach the interrupt outputs.

Six interrupt outputs leave the block. Lines 0 to 3 each have a private output. Lines 4 to 7 share a fifth output, and lines 8 to 23 share a sixth. Software configures and services the block over a plain 32-bit register bus. Reads are combinational from the address. A write clears a pending bit when the written bit is 1.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Line i has a 4-bit trigger field at bit offset (i mod 8)*4 of the configuration word at address 0x88 + 4*(i div 8), giving the words 0x88, 0x8C and 0x90. All 32 bits of these words are writable and read back as written.
- R2: Bits [2:0] of a trigger field select the mode and bit 3 has no effect. Code 0 is active-low level and code 1 is active-high level. When bit 2 is set the field detects rising edges, and when bit 1 is set it detects falling edges. So codes 2 and 3 are falling, codes 4 and 5 are rising, and codes 6 and 7 are both edges.
- R3: Each pin is synchronized by two flops. A pin change applied before clock edge k shows up in the pending register after edge k+2, and not before.
- R4: In a level mode the pending bit is set again on every clock while the level is active. A clear therefore has no lasting effect until the level goes away.
- R5: The pending register is at 0xA8 and holds bit i for line i. Writing 1 to bit i clears that bit, and writing 0 leaves it unchanged. A clear that lands in the same clock as a new event on that line leaves the bit set.
- R6: The mask register is at 0xA4. Bit i = 1 blocks line i from the outputs and 0 lets it through. A masked line still latches pending events.
- R7: Output bit j, for j = 0 to 3, is high exactly when pending bit j is set and mask bit j is clear.
- R8: Output bit 4 is high when any of lines 4 to 7 is pending and unmasked. Output bit 5 does the same for lines 8 to 23.
- R9: After reset the mask reads 0xFFFFFF, pending reads 0, every configuration word reads 0 and all outputs are low. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| extLine | input | 24 | Asynchronous external interrupt pins |
| busAddr | input | 8 | Register byte address |
| busWe | input | 1 | Write enable, sampled at the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 6 | Interrupt outputs: [3:0] lines 0-3, [4] lines 4-7, [5] lines 8-23 |

## Verification
The hardest case to reach is a pending-clear write that lands on the same clock edge as a fresh edge event on the same line. This only happens if the write is placed exactly two edges after the pin toggles, so that it meets the event coming out of the synchronizer. The bench counts those edges explicitly and issues the write on the third edge. It also times the synchronizer latency edge by edge. Level re-triggering is reached by clearing a level-mode bit while its pin stays active.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int LINES       = 24;
  localparam int FIELD_W     = 4;
  localparam int FIELDS_PW   = 8;
  localparam int DATA_W      = 32;
  localparam int CFG_WORDS   = LINES / FIELDS_PW;
  localparam int DEDICATED   = 4;
  localparam int IRQ_OUTS    = DEDICATED + 2;

  typedef struct packed {
    logic [CFG_WORDS-1:0] cfgWe;
    logic                 maskWe;
    logic                 pendClr;
    logic [DATA_W-1:0]    wdata;
  } ctrl_strobe_t;
endpackage

// File: rtl/ext_irq_regif.sv
module ext_irq_regif
  import ext_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 8'h88,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hA4,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'hA8
) (
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWe,
  input  logic [DATA_W-1:0]           busWdata,
  input  logic [CFG_WORDS*DATA_W-1:0] cfgFlat,
  input  logic [LINES-1:0]            maskQ,
  input  logic [LINES-1:0]            pendQ,
  output ctrl_strobe_t                strb,
  output logic [DATA_W-1:0]           busRdata
);
  localparam int PAD_W = DATA_W - LINES;

  logic [CFG_WORDS-1:0] cfgHit;

  genvar k;
  generate
    for (k = 0; k < CFG_WORDS; k++) begin : g_dec
      assign cfgHit[k] = (busAddr == ADDR_W'(CFG_BASE + ADDR_W'(4 * k)));
    end
  endgenerate

  always_comb begin
    strb.cfgWe   = busWe ? cfgHit : '0;
    strb.maskWe  = busWe && (busAddr == MASK_ADDR);
    strb.pendClr = busWe && (busAddr == PEND_ADDR);
    strb.wdata   = busWdata;
  end

  always_comb begin
    busRdata = '0;
    for (int w = 0; w < CFG_WORDS; w++) begin
      if (cfgHit[w]) busRdata = cfgFlat[w*DATA_W +: DATA_W];
    end
    if (busAddr == MASK_ADDR) busRdata = {{PAD_W{1'b0}}, maskQ};
    if (busAddr == PEND_ADDR) busRdata = {{PAD_W{1'b0}}, pendQ};
  end
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [LINES-1:0] GROUP_A = 24'h0000F0,
  parameter logic [LINES-1:0] GROUP_B = 24'hFFFF00
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LINES-1:0]            extLine,
  input  ctrl_strobe_t                strb,
  output logic [CFG_WORDS*DATA_W-1:0] cfgFlat,
  output logic [LINES-1:0]            maskQ,
  output logic [LINES-1:0]            pendQ,
  output logic [IRQ_OUTS-1:0]         irqOut
);
  logic [LINES-1:0]  syncQ [SYNC_STAGES];
  logic [LINES-1:0]  prevQ;
  logic [LINES-1:0]  syncOut;
  logic [LINES-1:0]  hitVec;
  logic [LINES-1:0]  pendNext;
  logic [LINES-1:0]  liveVec;
  logic [DATA_W-1:0] cfgQ [CFG_WORDS];

  // synchronizer chain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= extLine;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncOut;
    end
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  // trigger configuration words
  genvar k, i, j;
  generate
    for (k = 0; k < CFG_WORDS; k++) begin : g_cfg
      always_ff @(posedge clk) begin
        if (!rstN)               cfgQ[k] <= '0;
        else if (strb.cfgWe[k])  cfgQ[k] <= strb.wdata;
      end
      assign cfgFlat[k*DATA_W +: DATA_W] = cfgQ[k];
    end

    // per-line event detection
    for (i = 0; i < LINES; i++) begin : g_line
      logic [2:0] mode;
      assign mode = cfgQ[i / FIELDS_PW][(i % FIELDS_PW) * FIELD_W +: 3];
      always_comb begin
        if (mode[2:1] == 2'b00)
          hitVec[i] = (syncOut[i] == mode[0]);
        else
          hitVec[i] = (mode[2] & syncOut[i] & ~prevQ[i]) |
                      (mode[1] & ~syncOut[i] & prevQ[i]);
      end
    end
  endgenerate

  // mask and pending state
  always_comb begin
    pendNext = pendQ & ~(strb.pendClr ? strb.wdata[LINES-1:0] : '0);
    pendNext = pendNext | hitVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '1;
      pendQ <= '0;
    end else begin
      if (strb.maskWe) maskQ <= strb.wdata[LINES-1:0];
      pendQ <= pendNext;
    end
  end

  // output grouping
  assign liveVec = pendQ & ~maskQ;
  generate
    for (j = 0; j < DEDICATED; j++) begin : g_ded
      assign irqOut[j] = liveVec[j];
    end
  endgenerate
  assign irqOut[DEDICATED]   = |(liveVec & GROUP_A);
  assign irqOut[DEDICATED+1] = |(liveVec & GROUP_B);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 8'h88,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hA4,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'hA8,
  parameter int SYNC_STAGES = 2,
  parameter logic [LINES-1:0] GROUP_A = 24'h0000F0,
  parameter logic [LINES-1:0] GROUP_B = 24'hFFFF00
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LINES-1:0]    extLine,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic [IRQ_OUTS-1:0] irqOut
);
  ctrl_strobe_t                strb;
  logic [CFG_WORDS*DATA_W-1:0] cfgFlat;
  logic [LINES-1:0]            maskQ;
  logic [LINES-1:0]            pendQ;

  ext_irq_regif #(
    .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE),
    .MASK_ADDR(MASK_ADDR), .PEND_ADDR(PEND_ADDR)
  ) u_regif (
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .cfgFlat(cfgFlat), .maskQ(maskQ), .pendQ(pendQ),
    .strb(strb), .busRdata(busRdata)
  );

  ext_irq_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .GROUP_A(GROUP_A), .GROUP_B(GROUP_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .extLine(extLine), .strb(strb),
    .cfgFlat(cfgFlat), .maskQ(maskQ), .pendQ(pendQ), .irqOut(irqOut)
  );
endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker
  import ext_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hA4,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'hA8,
  parameter logic [LINES-1:0]  GROUP_B   = 24'hFFFF00
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [LINES-1:0]    busWdata,
  input logic [LINES-1:0]    maskQ,
  input logic [LINES-1:0]    pendQ,
  input logic [IRQ_OUTS-1:0] irqOut
);
  // R5
  w1c_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == PEND_ADDR) |=>
      ((($past(pendQ) & ~$past(busWdata)) & ~pendQ) == '0));

  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr == PEND_ADDR) |=> (($past(pendQ) & ~pendQ) == '0));

  // R6
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == MASK_ADDR) |=> (maskQ == $past(busWdata)));

  // R7
  ded_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut[0] |-> (pendQ[0] && !maskQ[0]));

  // R8
  grp_b_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((maskQ & GROUP_B) == GROUP_B) |-> !irqOut[DEDICATED+1]);
endmodule

bind ext_irq_ctrl ext_irq_checker #(
  .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .PEND_ADDR(PEND_ADDR), .GROUP_B(GROUP_B)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata[ext_irq_pkg::LINES-1:0]), .maskQ(maskQ), .pendQ(pendQ),
  .irqOut(irqOut)
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] extLine = '0;
  logic [7:0]  busAddr = 8'hA8;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [5:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rstN(rstN), .extLine(extLine), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0; busAddr = 8'hA8;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #0.5 d = busRdata;
    busAddr = 8'hA8;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearAll();
    writeReg(8'hA8, 32'hFFFFFF);
  endtask

  // R9: reset values and unmapped read
  task automatic testReset();
    logic [31:0] d;
    repeat (3) @(posedge clk);
    readReg(8'hA4, d); check("R9 mask reset", d, 32'h00FFFFFF);
    readReg(8'hA8, d); check("R9 pend reset", d, 32'h0);
    readReg(8'h8C, d); check("R9 cfg reset", d, 32'h0);
    check("R9 irq reset", {26'd0, irqOut}, 32'h0);
    rstN = 1'b1;
    readReg(8'h94, d); check("R9 unmapped read", d, 32'h0);
  endtask

  // R1: configuration words
  task automatic testCfg();
    logic [31:0] d;
    writeReg(8'h88, 32'h44444444);
    writeReg(8'h8C, 32'h44444444);
    writeReg(8'h90, 32'hA5C34444);
    readReg(8'h90, d); check("R1 cfg readback", d, 32'hA5C34444);
    writeReg(8'h90, 32'h44444444);
    clearAll();
    readReg(8'hA8, d); check("R1 pend clear after cfg", d, 32'h0);
  endtask

  // R3: synchronizer latency
  task automatic testLatency();
    @(negedge clk); extLine[5] = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 not after edge k", busRdata & 32'h20, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R3 not after edge k+1", busRdata & 32'h20, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R3 set after edge k+2", busRdata & 32'h20, 32'h20);
    extLine[5] = 1'b0;
    waitCyc(4);
    clearAll();
  endtask

  // R2: edge mode codes
  task automatic testModes();
    logic [31:0] d;
    writeReg(8'h8C, 32'h444C6324);
    clearAll();
    @(negedge clk); extLine[12:9] = 4'hF;
    waitCyc(4);
    readReg(8'hA8, d); check("R2 rising codes 6,C", d, 32'h001800);
    clearAll();
    @(negedge clk); extLine[12:9] = 4'h0;
    waitCyc(4);
    readReg(8'hA8, d); check("R2 falling codes 2,3,6", d, 32'h000E00);
    writeReg(8'h8C, 32'h44444444);
    clearAll();
  endtask

  // R4: level re-trigger
  task automatic testLevel();
    logic [31:0] d;
    writeReg(8'h88, 32'h44444401);
    waitCyc(3);
    clearAll();
    readReg(8'hA8, d); check("R4 low level active", d & 32'h3, 32'h2);
    @(negedge clk); extLine[0] = 1'b1;
    waitCyc(4);
    writeReg(8'hA8, 32'h1);
    readReg(8'hA8, d); check("R4 high level re-sets", d & 32'h1, 32'h1);
    @(negedge clk); extLine[0] = 1'b0; extLine[1] = 1'b1;
    waitCyc(4);
    writeReg(8'hA8, 32'h3);
    readReg(8'hA8, d); check("R4 level gone clears", d & 32'h3, 32'h0);
    writeReg(8'h88, 32'h44444444);
    clearAll();
  endtask

  // R5: selective and coincident clear
  task automatic testClear();
    logic [31:0] d;
    @(negedge clk); extLine[5:4] = 2'b11;
    waitCyc(4);
    writeReg(8'hA8, 32'h10);
    readReg(8'hA8, d); check("R5 write-zero keeps bit", d, 32'h20);
    clearAll();
    @(negedge clk); extLine[6] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); busWe = 1'b1; busAddr = 8'hA8; busWdata = 32'h40;
    @(posedge clk);
    @(negedge clk); busWe = 1'b0;
    check("R5 clear with event keeps", busRdata & 32'h40, 32'h40);
    clearAll();
    readReg(8'hA8, d); check("R5 clear after edge", d, 32'h0);
    @(negedge clk); extLine[6:4] = 3'b000;
    waitCyc(4);
  endtask

  // R6, R7, R8: masking and output grouping
  task automatic testOutputs();
    logic [31:0] d;
    clearAll();
    writeReg(8'hA4, 32'hFFFFF0);
    check("R7 no pending no irq", {26'd0, irqOut}, 32'h0);
    @(negedge clk); extLine[2] = 1'b1; extLine[7] = 1'b1;
    waitCyc(4);
    check("R7 line 2 dedicated", {26'd0, irqOut}, 32'h04);
    readReg(8'hA8, d); check("R6 masked still pends", d & 32'h80, 32'h80);
    writeReg(8'hA4, 32'hEFFF70);
    check("R8 group 4-7", {26'd0, irqOut}, 32'h14);
    @(negedge clk); extLine[20] = 1'b1;
    waitCyc(4);
    check("R8 group 8-23", {26'd0, irqOut}, 32'h34);
    writeReg(8'hA4, 32'hFFFFFF);
    check("R6 all masked", {26'd0, irqOut}, 32'h0);
  endtask

  initial begin
    testReset();
    testCfg();
    testLatency();
    testModes();
    testLevel();
    testClear();
    testOutputs();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule